// File: doc/BRIEF.md
# Periodic Queue Transaction Counter

This block limits how many transactions a periodic (interrupt) endpoint queue may issue during one visit of the schedule walker. When the walker fetches a queue head, the block loads a per-visit budget from the queue head's 2-bit multiplier field. A multiplier of zero loads a budget of four, so software that leaves the field unprogrammed still works. Execute requests are granted while budget remains. Each completed transaction uses up one unit of budget. Once the budget is spent, an execute request is refused with a go-horizontal pulse, which tells the walker to move on to the next queue head.

The queue kind (periodic or async) is captured at fetch time. Async queues bypass the budget entirely: they are always granted, never forced horizontal, and their completions leave the budget alone. A dispatch on an async queue also raises a queue-fill pulse so the walker can prefetch more transfers. A periodic dispatch goes straight back to horizontal traversal without filling. A transaction that was granted but not completed, for example because it was NAKed, can be requested again and is granted while budget remains.

Top module: `periodic_txn_ctr`

## Requirements
- R1: A synchronous active-low reset clears the budget to 0, selects the periodic queue kind, and drives exec_grant_o, go_horiz_o and fill_o low. A periodic execute request after reset, with no fetch, therefore yields go_horiz_o.
- R2: On fetch_i, a non-zero mult_i value m loads a budget of m. A periodic queue then receives exactly m grants, each followed by a completion, and the next request yields go_horiz_o.
- R3: On fetch_i, mult_i = 0 loads a budget of 4 instead of 0.
- R4: A periodic execute request with a budget of 0 produces no grant. It produces go_horiz_o for exactly one cycle.
- R5: A completion on a periodic queue decrements a non-zero budget by one. At 0 the budget stays at 0 and never wraps.
- R6: For an async queue (periodic_i = 0 at fetch), every execute request is granted and go_horiz_o never rises. Completions do not change the budget.
- R7: fill_o pulses together with exec_grant_o on an async dispatch and stays low on a periodic dispatch.
- R8: When fetch_i and done_i coincide, the fetch load wins. An exec_req_i in the same cycle as fetch_i is ignored.
- R9: All outputs are registered and appear in the cycle after the request. exec_grant_o and go_horiz_o are never high together.
- R10: A granted transaction with no completion, such as a NAKed packet, leaves the budget unchanged, so a repeated request is granted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_i | input | 1 | Queue head fetched this cycle |
| mult_i | input | 2 | Multiplier field of the fetched queue head |
| periodic_i | input | 1 | 1 = periodic queue, 0 = async queue (sampled at fetch) |
| exec_req_i | input | 1 | Request to execute a transaction |
| done_i | input | 1 | A transaction completed |
| exec_grant_o | output | 1 | Transaction dispatched (one-cycle pulse) |
| go_horiz_o | output | 1 | Budget exhausted, advance to next queue head (pulse) |
| fill_o | output | 1 | Async dispatch, queue filling allowed (pulse) |

## Verification
The assertions check, on every cycle, that the budget stays within 0 to 4 and that a fetch loads the decoded multiplier with zero mapped to four. They also check that a periodic completion takes away exactly one unit, and that grant and go-horizontal never coincide. Further per-cycle checks are that go-horizontal only appears for periodic queues, that fill only appears for async ones, and that neither answer appears without a request. Only the bench scenarios can show end-to-end counts: exactly m grants per visit, retries after a NAK, no wrap after surplus completions, and the priority of fetch over completion as seen through later grants.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    typedef enum logic {
        QK_PERIODIC = 1'b0,
        QK_ASYNC    = 1'b1
    } queue_kind_e;

    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_GRANT = 2'd1,
        ACT_HORIZ = 2'd2
    } dispatch_act_e;

endpackage

// File: rtl/ptc_load_decode.sv
module ptc_load_decode #(
    parameter int MULT_W = 2,
    localparam int CNT_W = MULT_W + 1
) (
    input  logic [MULT_W-1:0] mult_i,
    output logic [CNT_W-1:0]  load_o
);
    localparam logic [CNT_W-1:0] ZERO_SUB = CNT_W'(1) << MULT_W;

    always_comb begin
        if (mult_i == '0) begin
            load_o = ZERO_SUB;
        end else begin
            load_o = {1'b0, mult_i};
        end
    end
endmodule

// File: rtl/ptc_counter.sv
module ptc_counter
    import ptc_pkg::*;
#(
    parameter int MULT_W = 2,
    localparam int CNT_W = MULT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic             periodic_i,
    input  logic             done_i,
    output logic [CNT_W-1:0] cnt_o,
    output queue_kind_e      kind_o,
    output logic             exhausted_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        queue_kind_e      kind;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fetch_i) begin
            st_d.cnt  = load_i;
            st_d.kind = periodic_i ? QK_PERIODIC : QK_ASYNC;
        end else if (done_i && st_q.kind == QK_PERIODIC && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.kind <= QK_PERIODIC;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o       = st_q.cnt;
    assign kind_o      = st_q.kind;
    assign exhausted_o = (st_q.cnt == '0);
endmodule

// File: rtl/ptc_dispatch.sv
module ptc_dispatch
    import ptc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fetch_i,
    input  logic        exec_req_i,
    input  queue_kind_e kind_i,
    input  logic        exhausted_i,
    output logic        grant_o,
    output logic        horiz_o,
    output logic        fill_o
);
    typedef struct packed {
        dispatch_act_e act;
        logic          fill;
    } disp_state_t;

    disp_state_t st_d, st_q;

    always_comb begin
        st_d.act  = ACT_IDLE;
        st_d.fill = 1'b0;
        if (exec_req_i && !fetch_i) begin
            if (kind_i == QK_ASYNC) begin
                st_d.act  = ACT_GRANT;
                st_d.fill = 1'b1;
            end else if (exhausted_i) begin
                st_d.act = ACT_HORIZ;
            end else begin
                st_d.act = ACT_GRANT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.act  <= ACT_IDLE;
            st_q.fill <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o = (st_q.act == ACT_GRANT);
    assign horiz_o = (st_q.act == ACT_HORIZ);
    assign fill_o  = st_q.fill;
endmodule

// File: rtl/periodic_txn_ctr.sv
module periodic_txn_ctr
    import ptc_pkg::*;
#(
    parameter int MULT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_i,
    input  logic [MULT_W-1:0] mult_i,
    input  logic              periodic_i,
    input  logic              exec_req_i,
    input  logic              done_i,
    output logic              exec_grant_o,
    output logic              go_horiz_o,
    output logic              fill_o
);
    localparam int CNT_W = MULT_W + 1;

    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt_q;
    queue_kind_e      kind_q;
    logic             exhausted;

    ptc_load_decode #(.MULT_W(MULT_W)) dec_i (
        .mult_i (mult_i),
        .load_o (load_val)
    );

    ptc_counter #(.MULT_W(MULT_W)) cnt_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_i     (fetch_i),
        .load_i      (load_val),
        .periodic_i  (periodic_i),
        .done_i      (done_i),
        .cnt_o       (cnt_q),
        .kind_o      (kind_q),
        .exhausted_o (exhausted)
    );

    ptc_dispatch disp_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_i     (fetch_i),
        .exec_req_i  (exec_req_i),
        .kind_i      (kind_q),
        .exhausted_i (exhausted),
        .grant_o     (exec_grant_o),
        .horiz_o     (go_horiz_o),
        .fill_o      (fill_o)
    );
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker
    import ptc_pkg::*;
#(
    parameter int MULT_W = 2,
    localparam int CNT_W = MULT_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_i,
    input logic [MULT_W-1:0] mult_i,
    input logic              periodic_i,
    input logic              exec_req_i,
    input logic              done_i,
    input logic [CNT_W-1:0]  cnt_q,
    input queue_kind_e       kind_q,
    input logic              exec_grant_o,
    input logic              go_horiz_o,
    input logic              fill_o
);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(1) << MULT_W;

    // R3 / R5: budget never exceeds the zero-substitute value
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= MAX_CNT);

    // R2: non-zero multiplier loads as-is
    a_r2_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_i && mult_i != '0) |=> (cnt_q == {1'b0, $past(mult_i)}));

    // R3: zero multiplier loads four
    a_r3_zero_sub: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_i && mult_i == '0) |=> (cnt_q == MAX_CNT));

    // R5: periodic completion removes exactly one unit
    a_r5_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_i && done_i && kind_q == QK_PERIODIC && cnt_q != '0)
        |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R6: async completions leave the budget alone
    a_r6_async_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_i && kind_q == QK_ASYNC) |=> $stable(cnt_q));

    // R9: grant and go-horizontal are exclusive
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_grant_o && go_horiz_o));

    // R6: async queue never forced horizontal
    a_r6_no_async_horiz: assert property (@(posedge clk) disable iff (!rst_n)
        go_horiz_o |-> (kind_q == QK_PERIODIC));

    // R7: fill only with a grant on an async queue
    a_r7_fill_async: assert property (@(posedge clk) disable iff (!rst_n)
        fill_o |-> (exec_grant_o && kind_q == QK_ASYNC));

    // R8 / R9: an answer needs a request without a fetch in the prior cycle
    a_r8_need_req: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_req_i || fetch_i) |=> (!exec_grant_o && !go_horiz_o));
endmodule

bind periodic_txn_ctr ptc_checker #(.MULT_W(MULT_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_i      (fetch_i),
    .mult_i       (mult_i),
    .periodic_i   (periodic_i),
    .exec_req_i   (exec_req_i),
    .done_i       (done_i),
    .cnt_q        (cnt_q),
    .kind_q       (kind_q),
    .exec_grant_o (exec_grant_o),
    .go_horiz_o   (go_horiz_o),
    .fill_o       (fill_o)
);

// File: tb/periodic_txn_ctr_tb_top.sv
`timescale 1ns/1ps
module periodic_txn_ctr_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fetch_i = 1'b0;
    logic [1:0] mult_i = 2'd0;
    logic periodic_i = 1'b0;
    logic exec_req_i = 1'b0;
    logic done_i = 1'b0;
    logic exec_grant_o, go_horiz_o, fill_o;

    int checks = 0;
    int failures = 0;
    logic g, h, f;

    always #10 clk = ~clk;

    periodic_txn_ctr dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_i      (fetch_i),
        .mult_i       (mult_i),
        .periodic_i   (periodic_i),
        .exec_req_i   (exec_req_i),
        .done_i       (done_i),
        .exec_grant_o (exec_grant_o),
        .go_horiz_o   (go_horiz_o),
        .fill_o       (fill_o)
    );

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: {grant,horiz,fill} actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Called just after a negedge: drive, let one posedge pass, sample at the next negedge.
    task automatic cyc(input logic fe, input logic [1:0] m, input logic per,
                       input logic rq, input logic dn);
        fetch_i = fe; mult_i = m; periodic_i = per; exec_req_i = rq; done_i = dn;
        @(posedge clk);
        @(negedge clk);
        g = exec_grant_o; h = go_horiz_o; f = fill_o;
        fetch_i = 1'b0; exec_req_i = 1'b0; done_i = 1'b0;
    endtask

    task automatic fetch(input logic [1:0] m, input logic per);
        cyc(1'b1, m, per, 1'b0, 1'b0);
    endtask

    task automatic t_reset;
        check("R1 reset outputs", {exec_grant_o, go_horiz_o, fill_o}, 3'b000);
        cyc(1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
        check("R1 empty budget after reset", {g, h, f}, 3'b010);
    endtask

    // Periodic visit: expect exactly n grants, then go-horizontal.
    task automatic t_visit(input logic [1:0] m, input int n, input string req);
        fetch(m, 1'b1);
        for (int i = 0; i < n; i++) begin
            cyc(1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
            check(req, {g, h, f}, 3'b100);
            cyc(1'b0, 2'd0, 1'b1, 1'b0, 1'b1);
        end
        cyc(1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
        check(req, {g, h, f}, 3'b010);
        cyc(1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
        check("R4 horizontal is one cycle", {g, h, f}, 3'b000);
    endtask

    task automatic t_no_wrap;
        fetch(2'd1, 1'b1);
        cyc(1'b0, 2'd0, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) cyc(1'b0, 2'd0, 1'b1, 1'b0, 1'b1);
        cyc(1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
        check("R5 no wrap below zero", {g, h, f}, 3'b010);
    endtask

    task automatic t_async;
        fetch(2'd1, 1'b0);
        for (int i = 0; i < 6; i++) begin
            cyc(1'b0, 2'd0, 1'b0, 1'b1, 1'b0);
            check("R6/R7 async grant with fill", {g, h, f}, 3'b101);
            cyc(1'b0, 2'd0, 1'b0, 1'b0, 1'b1);
        end
    endtask

    task automatic t_nak_retry;
        fetch(2'd1, 1'b1);
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
            check("R10 NAK retry granted", {g, h, f}, 3'b100);
        end
        cyc(1'b0, 2'd0, 1'b1, 1'b0, 1'b1);
        cyc(1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
        check("R10 spent after completion", {g, h, f}, 3'b010);
    endtask

    task automatic t_priority;
        fetch(2'd1, 1'b1);
        cyc(1'b0, 2'd0, 1'b1, 1'b0, 1'b1);
        // fetch and done together: load 2 wins
        cyc(1'b1, 2'd2, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 2; i++) begin
            cyc(1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
            check("R8 fetch beats done", {g, h, f}, 3'b100);
            cyc(1'b0, 2'd0, 1'b1, 1'b0, 1'b1);
        end
        cyc(1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
        check("R8 budget of two spent", {g, h, f}, 3'b010);
        // request in the fetch cycle is ignored
        cyc(1'b1, 2'd3, 1'b1, 1'b1, 1'b0);
        check("R8 request during fetch ignored", {g, h, f}, 3'b000);
        cyc(1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
        check("R9 grant one cycle after request", {g, h, f}, 3'b100);
    endtask

    initial begin : watchdog
        #2000000;
        failures++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_visit(2'd1, 1, "R2 mult 1");
        t_visit(2'd2, 2, "R2 mult 2");
        t_visit(2'd3, 3, "R2 mult 3");
        t_visit(2'd0, 4, "R3 mult 0 gives 4");
        t_no_wrap();
        t_async();
        t_nak_retry();
        t_priority();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule